// File: doc/BRIEF.md
# Prioritized Precise Interrupt Cause Unit

This unit sits at the retirement point of an out-of-order core. Each cycle it looks at the cause bits carried by the instruction that is retiring, together with a set of external interrupt lines. It filters the maskable causes through the status register and picks the pending cause with the highest priority. When a cause is taken, it raises an interrupt request for one cycle. In that same cycle it presents the cause index, how execution resumes (abort, repeat or continue) and the new values for the exception status, exception cause, exception data and status registers.

The cause vector has one bit per cause, and a lower index means higher priority. The thirteen internal causes come first, in this order: reset (0), illegal instruction (1), misaligned access (2), instruction-fetch page fault (3), data page fault (4), trap (5), integer overflow (6), then the floating-point flags: overflow (7), underflow (8), inexact (9), divide by zero (10) and invalid (11), and finally unimplemented floating-point operation (12). External line k sits at index 13+k.

The control is a two-state machine. IDLE is the normal state, in which retirements are examined. TAKE lasts one cycle and drives the interrupt request while the pipeline flushes. The transition IDLE→TAKE fires on a retirement with a nonzero masked cause. The transition TAKE→IDLE is unconditional. Every other case keeps IDLE.

Top module: `irq_cause_unit`

## Requirements
- R1: After reset, irq_o is 0 and cause_idx_o, resume_o, esr_o, eca_o and edata_o are all zero.
- R2: Causes 6 to 11 and every external cause (index 13 and up) are maskable: one of them counts only when the status bit with the same index is 1. Causes 0 to 5 and 12 always count.
- R3: The selected cause index is the lowest index set in the masked cause vector.
- R4: resume_o encodes how execution resumes: 2'b00 abort for causes 0 to 2, 2'b01 repeat for causes 3 and 4, 2'b10 continue for cause 5 and every higher index.
- R5: When a cause is taken, esr_o shows the status register as it was at the retirement, eca_o shows the masked cause vector, and edata_o shows the retiring instruction's exception data.
- R6: sr_o is all zeros in the cycle irq_o is 1. In every other cycle it equals sr_i.
- R7: A cycle without retire_valid_i, or with a zero masked cause vector, takes nothing: irq_o stays 0 and the saved outputs keep their values.
- R8: irq_o is a one-cycle pulse in the cycle after the qualifying retirement. A retirement presented during that pulse cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retire_valid_i | input | 1 | An instruction retires this cycle |
| cause_i | input | 13 | Internal cause bits of the retiring instruction (indices 0 to 12) |
| ext_irq_i | input | NUM_EXT | External interrupt lines (indices 13 and up) |
| sr_i | input | 13+NUM_EXT | Status register, one mask bit per cause |
| edata_i | input | DATA_W | Exception data of the retiring instruction |
| irq_o | output | 1 | Interrupt request pulse |
| cause_idx_o | output | clog2(13+NUM_EXT) | Index of the selected cause |
| resume_o | output | 2 | Resume type: 00 abort, 01 repeat, 10 continue |
| esr_o | output | 13+NUM_EXT | New exception status register value |
| eca_o | output | 13+NUM_EXT | New exception cause register value |
| edata_o | output | DATA_W | New exception data register value |
| sr_o | output | 13+NUM_EXT | New status register value |

## Verification
The bench builds the unit with three external lines and a 16-bit data width. That gives a 16-entry cause vector, small enough to sweep every single cause against both settings of its mask bit, and every pair of causes. With this size each resume class, the split between maskable and non-maskable causes, and the priority of every index over every other can all be checked directly. A pseudo-random pass then mixes dense cause vectors with varied status values. Directed steps cover retirements that carry no masked cause and a retirement that arrives during the flush cycle.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;

    localparam int INT_CAUSES = 13;

    typedef enum logic [1:0] {
        RES_ABORT    = 2'b00,
        RES_REPEAT   = 2'b01,
        RES_CONTINUE = 2'b10
    } resume_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_TAKE = 1'b1
    } irq_state_e;

    function automatic logic cause_maskable(input int idx);
        return (idx >= 6 && idx <= 11) || (idx >= INT_CAUSES);
    endfunction

    function automatic resume_e cause_resume(input int idx);
        if (idx <= 2)      return RES_ABORT;
        else if (idx <= 4) return RES_REPEAT;
        else               return RES_CONTINUE;
    endfunction

endpackage

// File: rtl/irq_cause_mask.sv
module irq_cause_mask
    import irq_cause_pkg::*;
#(
    parameter int NCAUSE = 16
) (
    input  logic [NCAUSE-1:0] raw_i,
    input  logic [NCAUSE-1:0] sr_i,
    output logic [NCAUSE-1:0] masked_o,
    output logic              any_o
);

    for (genvar g = 0; g < NCAUSE; g++) begin : g_bit
        if (cause_maskable(g)) begin : g_mask
            assign masked_o[g] = raw_i[g] & sr_i[g];
        end else begin : g_pass
            assign masked_o[g] = raw_i[g];
        end
    end

    assign any_o = |masked_o;

endmodule

// File: rtl/irq_cause_prio.sv
module irq_cause_prio
    import irq_cause_pkg::*;
#(
    parameter int NCAUSE = 16,
    localparam int IDX_W = $clog2(NCAUSE)
) (
    input  logic [NCAUSE-1:0] vec_i,
    output logic [IDX_W-1:0]  idx_o,
    output resume_e           resume_o
);

    always_comb begin
        idx_o    = '0;
        resume_o = RES_ABORT;
        for (int i = NCAUSE - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o    = IDX_W'(i);
                resume_o = cause_resume(i);
            end
        end
    end

endmodule

// File: rtl/irq_cause_unit.sv
module irq_cause_unit
    import irq_cause_pkg::*;
#(
    parameter int NUM_EXT = 19,
    parameter int DATA_W  = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              retire_valid_i,
    input  logic [12:0]                       cause_i,
    input  logic [NUM_EXT-1:0]                ext_irq_i,
    input  logic [13+NUM_EXT-1:0]             sr_i,
    input  logic [DATA_W-1:0]                 edata_i,
    output logic                              irq_o,
    output logic [$clog2(13+NUM_EXT)-1:0]     cause_idx_o,
    output logic [1:0]                        resume_o,
    output logic [13+NUM_EXT-1:0]             esr_o,
    output logic [13+NUM_EXT-1:0]             eca_o,
    output logic [DATA_W-1:0]                 edata_o,
    output logic [13+NUM_EXT-1:0]             sr_o
);

    localparam int NCAUSE = INT_CAUSES + NUM_EXT;
    localparam int IDX_W  = $clog2(NCAUSE);

    logic [NCAUSE-1:0] raw_vec;
    logic [NCAUSE-1:0] masked_vec;
    logic              hit_any;
    logic [IDX_W-1:0]  sel_idx;
    resume_e           sel_resume;

    irq_state_e        state_q, state_d;
    logic              take;

    logic [IDX_W-1:0]  idx_q;
    resume_e           resume_q;
    logic [NCAUSE-1:0] esr_q;
    logic [NCAUSE-1:0] eca_q;
    logic [DATA_W-1:0] edata_q;

    assign raw_vec = {ext_irq_i, cause_i};

    irq_cause_mask #(.NCAUSE(NCAUSE)) u_mask (
        .raw_i    (raw_vec),
        .sr_i     (sr_i),
        .masked_o (masked_vec),
        .any_o    (hit_any)
    );

    irq_cause_prio #(.NCAUSE(NCAUSE)) u_prio (
        .vec_i    (masked_vec),
        .idx_o    (sel_idx),
        .resume_o (sel_resume)
    );

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (retire_valid_i && hit_any) begin
                    take    = 1'b1;
                    state_d = ST_TAKE;
                end
            end
            ST_TAKE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            idx_q    <= '0;
            resume_q <= RES_ABORT;
            esr_q    <= '0;
            eca_q    <= '0;
            edata_q  <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                idx_q    <= sel_idx;
                resume_q <= sel_resume;
                esr_q    <= sr_i;
                eca_q    <= masked_vec;
                edata_q  <= edata_i;
            end
        end
    end

    always_comb begin
        irq_o       = (state_q == ST_TAKE);
        cause_idx_o = idx_q;
        resume_o    = resume_q;
        esr_o       = esr_q;
        eca_o       = eca_q;
        edata_o     = edata_q;
        sr_o        = (state_q == ST_TAKE) ? '0 : sr_i;
    end

endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk
    import irq_cause_pkg::*;
#(
    parameter int NUM_EXT = 19,
    parameter int DATA_W  = 32,
    localparam int NC     = INT_CAUSES + NUM_EXT,
    localparam int IW     = $clog2(NC)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          retire_valid_i,
    input logic [NC-1:0] sr_i,
    input logic [NC-1:0] masked_i,
    input logic          irq_o,
    input logic [IW-1:0] cause_idx_o,
    input logic [NC-1:0] esr_o,
    input logic [NC-1:0] eca_o,
    input logic [NC-1:0] sr_o
);

    logic [NC-1:0] maskable_bits;
    logic [NC-1:0] one_vec;

    always_comb begin
        for (int i = 0; i < NC; i++) maskable_bits[i] = cause_maskable(i);
        one_vec = NC'(1);
    end

    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    a_r8_take_next: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid_i && (masked_i != '0) && !irq_o) |=> irq_o);

    a_r6_sr_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (sr_o == '0));

    a_r5_esr_saved: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (esr_o == $past(sr_i)));

    a_r2_masked_out: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((eca_o & maskable_bits & ~esr_o) == '0));

    a_r3_lowest_index: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (eca_o[cause_idx_o] &&
                   ((eca_o & ((one_vec << cause_idx_o) - one_vec)) == '0)));

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!retire_valid_i || irq_o || (masked_i == '0)) |=>
            ($stable(eca_o) && $stable(esr_o) && !irq_o));

endmodule

bind irq_cause_unit irq_cause_chk #(.NUM_EXT(NUM_EXT), .DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .retire_valid_i (retire_valid_i),
    .sr_i           (sr_i),
    .masked_i       (masked_vec),
    .irq_o          (irq_o),
    .cause_idx_o    (cause_idx_o),
    .esr_o          (esr_o),
    .eca_o          (eca_o),
    .sr_o           (sr_o)
);

// File: tb/irq_cause_unit_tb.sv
module irq_cause_unit_tb;

    localparam int NEXT = 3;
    localparam int DW   = 16;
    localparam int NC   = 13 + NEXT;
    localparam int IW   = $clog2(NC);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rv = 1'b0;
    logic [12:0]   cause = '0;
    logic [NEXT-1:0] ext = '0;
    logic [NC-1:0] sr = '0;
    logic [DW-1:0] edata = '0;
    logic          irq;
    logic [IW-1:0] idx;
    logic [1:0]    resume;
    logic [NC-1:0] esr, eca, sr_new;
    logic [DW-1:0] edata_out;

    int checks = 0;
    int errors = 0;

    logic [NC-1:0] exp_esr = '0;
    logic [NC-1:0] exp_eca = '0;
    logic [DW-1:0] exp_ed  = '0;
    logic [IW-1:0] exp_idx = '0;
    logic [1:0]    exp_res = '0;

    always #5 clk = ~clk;

    irq_cause_unit #(.NUM_EXT(NEXT), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .retire_valid_i(rv), .cause_i(cause),
        .ext_irq_i(ext), .sr_i(sr), .edata_i(edata), .irq_o(irq),
        .cause_idx_o(idx), .resume_o(resume), .esr_o(esr), .eca_o(eca),
        .edata_o(edata_out), .sr_o(sr_new)
    );

    task automatic check(input logic ok, input string tag, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic logic is_maskable(input int i);
        return (i >= 6 && i <= 11) || i >= 13;
    endfunction

    function automatic logic [1:0] res_of(input int i);
        if (i <= 2) return 2'b00;
        if (i <= 4) return 2'b01;
        return 2'b10;
    endfunction

    function automatic logic [NC-1:0] mask_model(input logic [NC-1:0] c, input logic [NC-1:0] s);
        logic [NC-1:0] m;
        for (int i = 0; i < NC; i++) m[i] = c[i] & (!is_maskable(i) | s[i]);
        return m;
    endfunction

    task automatic check_saved();
        check(idx == exp_idx, "R3", idx, exp_idx);
        check(resume == exp_res, "R4", resume, exp_res);
        check(esr == exp_esr, "R5", esr, exp_esr);
        check(eca == exp_eca, "R2", eca, exp_eca);
        check(edata_out == exp_ed, "R5", edata_out, exp_ed);
    endtask

    // one retirement followed by an idle cycle
    task automatic step(input logic v, input logic [NC-1:0] c, input logic [NC-1:0] s, input logic [DW-1:0] d);
        logic [NC-1:0] m;
        logic tk;
        @(negedge clk);
        rv = v; {ext, cause} = c; sr = s; edata = d;
        m  = mask_model(c, s);
        tk = v && (m != '0);
        if (tk) begin
            exp_eca = m; exp_esr = s; exp_ed = d;
            exp_idx = '0;
            for (int i = NC - 1; i >= 0; i--) if (m[i]) exp_idx = IW'(i);
            exp_res = res_of(int'(exp_idx));
        end
        @(posedge clk); #1;
        check(irq == tk, tk ? "R8" : "R7", irq, tk);
        if (tk) check(sr_new == '0, "R6", sr_new, 0);
        else    check(sr_new == s, "R6", sr_new, s);
        check_saved();
        @(negedge clk);
        rv = 1'b0;
        @(posedge clk); #1;
        check(irq == 1'b0, "R8", irq, 0);
        check(sr_new == sr, "R6", sr_new, sr);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        #23;
        check(irq == 1'b0, "R1", irq, 0);
        check(idx == '0 && resume == '0, "R1", {idx, resume}, 0);
        check(esr == '0 && eca == '0 && edata_out == '0, "R1", eca, 0);
        rst_n = 1'b1;

        // single causes, mask bit off then on
        for (int i = 0; i < NC; i++) begin
            step(1'b1, NC'(1) << i, '0, DW'(i * 37 + 1));
            step(1'b1, NC'(1) << i, NC'(1) << i, DW'(i * 91 + 5));
        end
        // every pair, all mask bits open
        for (int i = 0; i < NC; i++)
            for (int j = i + 1; j < NC; j++)
                step(1'b1, (NC'(1) << i) | (NC'(1) << j), '1, DW'(i * 16 + j));
        // no retirement: nothing taken
        step(1'b0, '1, '1, 16'hdead);
        // only maskable causes, closed mask
        step(1'b1, 16'hEFC0, 16'h1000, 16'h0bad);
        // retirement during the flush cycle is ignored (R8)
        @(negedge clk);
        rv = 1'b1; {ext, cause} = NC'(1) << 5; sr = '0; edata = 16'h1234;
        exp_eca = NC'(1) << 5; exp_esr = '0; exp_ed = 16'h1234; exp_idx = 5; exp_res = 2'b10;
        @(posedge clk); #1;
        check(irq == 1'b1, "R8", irq, 1);
        @(negedge clk);
        {ext, cause} = NC'(1); sr = 16'h00ff; edata = 16'h5678;
        @(posedge clk); #1;
        check(irq == 1'b0, "R8", irq, 0);
        check_saved();
        @(negedge clk); rv = 1'b0;
        @(posedge clk); #1;
        // pseudo-random mixes
        lfsr = 32'hace1_2345;
        for (int k = 0; k < 300; k++) begin
            logic [31:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = lfsr;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(a[31] | a[30], a[15:0] & {a[29:16], 2'b11} & ~16'h0001, lfsr[15:0], lfsr[31:16]);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule